// File: doc/BRIEF.md
# SEC-DED Memory Word Protection (72,64)

This block guards a 64-bit memory word with 8 check bits. The encoder side takes a data word on its way into storage and produces a 72-bit codeword. The decoder side takes a 72-bit word read back from storage and computes its syndrome. It repairs any single flipped bit and reports any two flipped bits as uncorrectable, without altering the data in that case.

The check matrix is built only from distinct columns of odd weight. Data bits use the lightest columns available, which keeps the XOR trees shallow. Because every column has odd weight, a double error is recognised by its even-weight nonzero syndrome, and no separate overall parity bit is needed.

Both paths are combinational. The parameter `OUT_REG` (default 1) adds one register stage on every output. The column table is computed from a rule at elaboration time, and the encoder and decoder share it.

Top module: `ecc_secded`

## Requirements
- R1: The codeword places the data unchanged in bits [63:0] and the check bits in [71:64]. Check bit j is the XOR of all data bits whose column has bit j set.
- R2: Data columns are assigned by ascending weight (3, then 5), and by ascending value within a weight. Data bit 0 has column 8'h07, bit 55 has 8'hE0, bit 56 has 8'h1F and bit 63 has 8'h57. Check bit j has column 1<<j.
- R3: The syndrome is the recomputed check bits XOR the received check bits. A zero syndrome raises the clean flag and passes the data through unchanged.
- R4: A single flipped data bit yields that bit's column as the syndrome. The fixed flag rises and the data output has the bit restored.
- R5: A single flipped check bit yields a one-hot syndrome. The fixed flag rises and the data output equals the received data.
- R6: Two flipped bits yield an even-weight nonzero syndrome. The uncorrectable flag rises and the data output equals the received data bits unmodified.
- R7: An odd-weight nonzero syndrome that matches no column (e.g. 8'h7F) raises the uncorrectable flag and modifies no data bit.
- R8: Exactly one of the clean, fixed and uncorrectable flags is high for every result.
- R9: With `OUT_REG`=1, every output reflects the inputs sampled at the previous rising clock edge. While `rst_n` is low at a clock edge, the outputs clear to zero data, zero codeword, zero syndrome and clean flag high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Synchronous active-low reset |
| enc_data_i | input | 64 | Data word to encode |
| enc_code_o | output | 72 | Codeword: check bits [71:64], data [63:0] |
| dec_code_i | input | 72 | Received codeword to check |
| dec_data_o | output | 64 | Corrected (or passed-through) data |
| dec_clean_o | output | 1 | Syndrome was zero |
| dec_fixed_o | output | 1 | One bit was corrected |
| dec_uncorr_o | output | 1 | Error detected but not correctable |
| dec_syndrome_o | output | 8 | Raw syndrome |

## Verification
With the default single output stage, the encoder codeword and all decoder results are due one rising edge after their inputs are applied. The bench drives inputs on a falling edge and reads results at the next falling edge, exactly one register later. In one case it also samples one nanosecond after driving, to confirm the old result still stands before that edge. Reset values are checked after reset has been held across several edges with nonzero inputs present.

// File: rtl/ecc_pkg.sv
// Shared constants and the column-assignment rule for the SEC-DED code.
// Assumes an odd-weight column code with an identity block for check bits.
package ecc_pkg;

    localparam int DATA_W = 64;
    localparam int CHK_W  = 8;
    localparam int CODE_W = DATA_W + CHK_W;

    // Count set bits of a non-negative integer.
    function automatic int popcnt(input int v);
        int n;
        n = 0;
        for (int b = 0; b < 31; b++) begin
            n += (v >> b) & 1;
        end
        return n;
    endfunction

    // Column of data bit idx: odd weights from 3 upward, ascending value inside a weight.
    function automatic int data_col(input int idx, input int chk_w);
        int n;
        int res;
        n   = 0;
        res = 0;
        for (int w = 3; w <= chk_w; w += 2) begin
            for (int v = 0; v < (1 << chk_w); v++) begin
                if (popcnt(v) == w) begin
                    if (n == idx) begin
                        res = v;
                    end
                    n++;
                end
            end
        end
        return res;
    endfunction

endpackage

// File: rtl/ecc_check_gen.sv
// Check-bit generator: XOR of the columns of all set data bits.
// Assumes DATA_W does not exceed the count of odd-weight columns of weight >= 3.
module ecc_check_gen #(
    parameter int DATA_W = ecc_pkg::DATA_W,
    parameter int CHK_W  = ecc_pkg::CHK_W
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [CHK_W-1:0]  chk_o
);

    logic [CHK_W-1:0] term [DATA_W];

    // Each data bit contributes its column when set.
    for (genvar i = 0; i < DATA_W; i++) begin : g_term
        localparam logic [CHK_W-1:0] COL = CHK_W'(ecc_pkg::data_col(i, CHK_W));
        assign term[i] = data_i[i] ? COL : '0;
    end

    // Fold all contributions into the check vector.
    always_comb begin
        chk_o = '0;
        for (int i = 0; i < DATA_W; i++) begin
            chk_o = chk_o ^ term[i];
        end
    end

endmodule

// File: rtl/ecc_encoder.sv
// Systematic encoder: appends generated check bits above the data.
// Assumes the shared column rule from ecc_pkg.
module ecc_encoder #(
    parameter int DATA_W = ecc_pkg::DATA_W,
    parameter int CHK_W  = ecc_pkg::CHK_W,
    localparam int CODE_W = DATA_W + CHK_W
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [CODE_W-1:0] code_o
);

    logic [CHK_W-1:0] chk;

    ecc_check_gen #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_gen (
        .data_i (data_i),
        .chk_o  (chk)
    );

    // Data passes unchanged; check bits sit in the upper field.
    assign code_o = {chk, data_i};

endmodule

// File: rtl/ecc_decoder.sv
// Decoder: forms the syndrome, classifies it, and flips the matched data bit.
// Assumes all columns are distinct and odd-weight, so an even nonzero
// syndrome can only come from an uncorrectable pattern.
module ecc_decoder #(
    parameter int DATA_W = ecc_pkg::DATA_W,
    parameter int CHK_W  = ecc_pkg::CHK_W,
    localparam int CODE_W = DATA_W + CHK_W
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [DATA_W-1:0] data_o,
    output logic              clean_o,
    output logic              fixed_o,
    output logic              uncorr_o,
    output logic [CHK_W-1:0]  syn_o
);

    logic [DATA_W-1:0] rx_data;
    logic [CHK_W-1:0]  rx_chk;
    logic [CHK_W-1:0]  recalc;
    logic [CHK_W-1:0]  syn;
    logic [DATA_W-1:0] data_hit;
    logic              chk_hit;

    assign rx_data = code_i[DATA_W-1:0];
    assign rx_chk  = code_i[CODE_W-1:DATA_W];

    ecc_check_gen #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_gen (
        .data_i (rx_data),
        .chk_o  (recalc)
    );

    // Syndrome: recomputed check bits against received ones.
    assign syn = recalc ^ rx_chk;

    // One comparator per data bit against its fixed column.
    for (genvar i = 0; i < DATA_W; i++) begin : g_match
        localparam logic [CHK_W-1:0] COL = CHK_W'(ecc_pkg::data_col(i, CHK_W));
        assign data_hit[i] = (syn == COL);
    end

    // Check-bit columns are the identity, so a one-hot syndrome names a check bit.
    assign chk_hit = (syn != '0) && ((syn & (syn - 1'b1)) == '0);

    // Classification and correction.
    always_comb begin
        clean_o  = (syn == '0);
        fixed_o  = chk_hit || (|data_hit);
        uncorr_o = !clean_o && !fixed_o;
        data_o   = rx_data ^ data_hit;
        syn_o    = syn;
    end

endmodule

// File: rtl/ecc_secded.sv
// Top: SEC-DED encoder and decoder with an optional output register stage.
// Assumes synchronous active-low reset; with OUT_REG=0 clk and rst_n only
// feed the assertion bookkeeping.
module ecc_secded #(
    parameter int DATA_W  = ecc_pkg::DATA_W,
    parameter int CHK_W   = ecc_pkg::CHK_W,
    parameter bit OUT_REG = 1'b1,
    localparam int CODE_W = DATA_W + CHK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] enc_data_i,
    output logic [CODE_W-1:0] enc_code_o,
    input  logic [CODE_W-1:0] dec_code_i,
    output logic [DATA_W-1:0] dec_data_o,
    output logic              dec_clean_o,
    output logic              dec_fixed_o,
    output logic              dec_uncorr_o,
    output logic [CHK_W-1:0]  dec_syndrome_o
);

    logic [CODE_W-1:0] enc_code;
    logic [DATA_W-1:0] dec_data;
    logic              dec_clean;
    logic              dec_fixed;
    logic              dec_uncorr;
    logic [CHK_W-1:0]  dec_syn;
    logic              live_q;

    ecc_encoder #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_enc (
        .data_i (enc_data_i),
        .code_o (enc_code)
    );

    ecc_decoder #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_dec (
        .code_i   (dec_code_i),
        .data_o   (dec_data),
        .clean_o  (dec_clean),
        .fixed_o  (dec_fixed),
        .uncorr_o (dec_uncorr),
        .syn_o    (dec_syn)
    );

    // Marks that at least one edge has passed since reset released.
    always_ff @(posedge clk) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    if (OUT_REG) begin : g_reg
        // Output stage: registers every result, clean state on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                enc_code_o     <= '0;
                dec_data_o     <= '0;
                dec_clean_o    <= 1'b1;
                dec_fixed_o    <= 1'b0;
                dec_uncorr_o   <= 1'b0;
                dec_syndrome_o <= '0;
            end else begin
                enc_code_o     <= enc_code;
                dec_data_o     <= dec_data;
                dec_clean_o    <= dec_clean;
                dec_fixed_o    <= dec_fixed;
                dec_uncorr_o   <= dec_uncorr;
                dec_syndrome_o <= dec_syn;
            end
        end

        AST_ENC_DATA_PASS: assert property (@(posedge clk) disable iff (!rst_n)
            live_q |-> enc_code_o[DATA_W-1:0] == $past(enc_data_i)); // R1
        AST_UNCORR_RAW: assert property (@(posedge clk) disable iff (!rst_n)
            (live_q && dec_uncorr_o) |-> dec_data_o == $past(dec_code_i[DATA_W-1:0])); // R6
    end else begin : g_comb
        // Pass-through: results leave combinationally.
        always_comb begin
            enc_code_o     = enc_code;
            dec_data_o     = dec_data;
            dec_clean_o    = dec_clean;
            dec_fixed_o    = dec_fixed;
            dec_uncorr_o   = dec_uncorr;
            dec_syndrome_o = dec_syn;
        end
    end

    AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({dec_clean_o, dec_fixed_o, dec_uncorr_o})); // R8
    AST_CLEAN_ZERO_SYN: assert property (@(posedge clk) disable iff (!rst_n)
        dec_clean_o |-> dec_syndrome_o == '0); // R3
    AST_FIXED_ODD_SYN: assert property (@(posedge clk) disable iff (!rst_n)
        dec_fixed_o |-> ^dec_syndrome_o); // R4
    AST_EVEN_IS_UNCORR: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_syndrome_o != '0 && !(^dec_syndrome_o)) |-> dec_uncorr_o); // R6

endmodule

// File: tb/ecc_secded_tb_top.sv
`timescale 1ns/1ps
module ecc_secded_tb_top;

    localparam int DW = 64;
    localparam int CW = 8;
    localparam int NW = DW + CW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] enc_data_i = '0;
    logic [NW-1:0] enc_code_o;
    logic [NW-1:0] dec_code_i = '0;
    logic [DW-1:0] dec_data_o;
    logic          dec_clean_o, dec_fixed_o, dec_uncorr_o;
    logic [CW-1:0] dec_syndrome_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ecc_secded dut_i (
        .clk(clk), .rst_n(rst_n),
        .enc_data_i(enc_data_i), .enc_code_o(enc_code_o),
        .dec_code_i(dec_code_i), .dec_data_o(dec_data_o),
        .dec_clean_o(dec_clean_o), .dec_fixed_o(dec_fixed_o),
        .dec_uncorr_o(dec_uncorr_o), .dec_syndrome_o(dec_syndrome_o)
    );

    // Column of data bit per the R2 rule: odd weights from 3, ascending value.
    function automatic logic [CW-1:0] tb_col(input int idx);
        int n = 0;
        logic [CW-1:0] r = '0;
        for (int w = 3; w <= CW; w += 2)
            for (int v = 0; v < 256; v++)
                if ($countones(v[7:0]) == w) begin
                    if (n == idx) r = v[7:0];
                    n++;
                end
        return r;
    endfunction

    function automatic logic [CW-1:0] tb_chk(input logic [DW-1:0] d);
        logic [CW-1:0] c = '0;
        for (int i = 0; i < DW; i++) if (d[i]) c ^= tb_col(i);
        return c;
    endfunction

    function automatic logic [CW-1:0] tb_syn(input logic [NW-1:0] flip);
        logic [CW-1:0] s = '0;
        for (int i = 0; i < DW; i++) if (flip[i]) s ^= tb_col(i);
        for (int j = 0; j < CW; j++) if (flip[DW+j]) s ^= CW'(1 << j);
        return s;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [NW-1:0] act, input logic [NW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // kind: 0 clean, 1 fixed, 2 uncorrectable
    typedef struct packed {
        logic [DW-1:0] d;
        logic [NW-1:0] flip;
        logic [1:0]    kind;
        logic [3:0]    req;
    } vec_t;

    localparam vec_t VECS [11] = '{
        '{64'h0, 72'h0, 2'd0, 4'd3},
        '{64'hFFFF_FFFF_FFFF_FFFF, 72'h0, 2'd0, 4'd3},
        '{64'h0123_4567_89AB_CDEF, 72'h1, 2'd1, 4'd4},
        '{64'hA5A5_A5A5_A5A5_A5A5, 72'h1 << 63, 2'd1, 4'd4},
        '{64'hDEAD_BEEF_0BAD_F00D, 72'h1 << 56, 2'd1, 4'd4},
        '{64'h1357_9BDF_2468_ACE0, 72'h1 << 64, 2'd1, 4'd5},
        '{64'hFEDC_BA98_7654_3210, 72'h1 << 71, 2'd1, 4'd5},
        '{64'h0F0F_0F0F_0F0F_0F0F, (72'h1 << 3) | (72'h1 << 40), 2'd2, 4'd6},
        '{64'h3333_CCCC_5555_AAAA, (72'h1 << 10) | (72'h1 << 66), 2'd2, 4'd6},
        '{64'h8000_0000_0000_0001, 72'h7F << 64, 2'd2, 4'd7},
        '{64'h7777_8888_9999_6666, 72'h3 << 70, 2'd2, 4'd6}
    };

    function automatic string req_name(input logic [3:0] r);
        case (r)
            4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            default: return "R7";
        endcase
    endfunction

    initial begin
        #(200000 * 5);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [NW-1:0] code;
        logic [2:0] exp_flags;
        // Reset with nonzero inputs present (R9).
        enc_data_i = 64'hFFFF_0000_FFFF_0000;
        dec_code_i = {8'hFF, 64'h1234_5678_9ABC_DEF0};
        repeat (4) @(negedge clk);
        check("R9", "reset codeword", enc_code_o, '0);
        check("R9", "reset data", NW'(dec_data_o), '0);
        check("R9", "reset syndrome", NW'(dec_syndrome_o), '0);
        check("R9", "reset flags", NW'({dec_clean_o, dec_fixed_o, dec_uncorr_o}), NW'(3'b100));
        rst_n = 1'b1;

        // Table walk: R1, R3..R8.
        foreach (VECS[k]) begin
            @(negedge clk);
            enc_data_i = VECS[k].d;
            code = {tb_chk(VECS[k].d), VECS[k].d};
            dec_code_i = code ^ VECS[k].flip;
            @(negedge clk);
            check("R1", "codeword", enc_code_o, code);
            check(req_name(VECS[k].req), "syndrome", NW'(dec_syndrome_o), NW'(tb_syn(VECS[k].flip)));
            check(req_name(VECS[k].req), "data",
                  NW'(dec_data_o),
                  NW'((VECS[k].kind == 2'd2) ? (VECS[k].d ^ VECS[k].flip[DW-1:0]) : VECS[k].d));
            exp_flags = (VECS[k].kind == 2'd0) ? 3'b100 : (VECS[k].kind == 2'd1) ? 3'b010 : 3'b001;
            // R8: exactly the expected single flag is high
            check("R8", "flags", NW'({dec_clean_o, dec_fixed_o, dec_uncorr_o}), NW'(exp_flags));
        end

        // R2: literal column values for selected data bits.
        @(negedge clk); enc_data_i = 64'h1;
        @(negedge clk); check("R2", "col bit0", NW'(enc_code_o[71:64]), NW'(8'h07));
        enc_data_i = 64'h1 << 55;
        @(negedge clk); check("R2", "col bit55", NW'(enc_code_o[71:64]), NW'(8'hE0));
        enc_data_i = 64'h1 << 56;
        @(negedge clk); check("R2", "col bit56", NW'(enc_code_o[71:64]), NW'(8'h1F));
        enc_data_i = 64'h1 << 63;
        @(negedge clk); check("R2", "col bit63", NW'(enc_code_o[71:64]), NW'(8'h57));

        // R9: output holds until the next rising edge, then updates.
        enc_data_i = 64'hCAFE_F00D_1234_5678;
        #1 check("R9", "before edge", enc_code_o, {8'h57, 64'h1 << 63});
        @(negedge clk);
        check("R9", "after edge", enc_code_o, {tb_chk(64'hCAFE_F00D_1234_5678), 64'hCAFE_F00D_1234_5678});

        // R9: mid-run reset clears a pending uncorrectable result.
        dec_code_i = {tb_chk(64'h5), 64'h5} ^ 72'h3;
        @(negedge clk);
        check("R6", "pre-reset uncorr", NW'(dec_uncorr_o), NW'(1'b1));
        rst_n = 1'b0;
        @(negedge clk);
        check("R9", "mid-run reset flags", NW'({dec_clean_o, dec_fixed_o, dec_uncorr_o}), NW'(3'b100));
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule